// File: doc/BRIEF.md
# GPIO Bank with Masked Output Writes

This block holds the pin state of one general-purpose I/O bank of up to 32 pins behind a plain 32-bit register bus. For each pin it keeps a direction bit, an output-enable bit and an output data bit. It drives a pad output value and a pad tri-state enable for every pin, and it returns the pad input levels through a two-stage synchronizer.

Software updates output data through two write-only half-word ports. Each port carries a 16-bit write mask in its upper half and 16 data bits in its lower half, so any subset of pins can change in a single write with no read-modify-write. A mask bit of 0 lets the matching data bit through. The low port covers pins 0 to 15 and the high port covers pins 16 to 31.

The bank index is a parameter. In bank 0, pins 7 and 8 are held as outputs. A bank can be built with fewer than 32 pins; any bit above the pin count reads 0 and is never written.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset, output-enable and output data are all 0. Direction is also 0, except that in bank 0 the direction bits of pins 7 and 8 reset to 1.
- R2: A write to offset 0x00 treats wdata[31:16] as a mask and wdata[15:0] as data for pins 0..15. Pin i takes wdata[i] when wdata[16+i] is 0 and keeps its value when wdata[16+i] is 1.
- R3: A write to offset 0x04 follows the same rule for pins 16..31. Pin 16+i takes wdata[i] when wdata[16+i] is 0 and keeps its value otherwise.
- R4: Offsets 0x00 and 0x04 are write-only and always read 0.
- R5: Offset 0x08 is read-only. Bit i returns the level of pad input i as it stood two rising clock edges earlier. Writes to 0x08 change no state.
- R6: The direction register at 0x0C (1 = output, 0 = input) and the output-enable register at 0x10 are read/write and keep their value when no write targets them.
- R7: pad_oe[i] is 1 exactly when pin i is set as an output and its output-enable bit is 1.
- R8: pad_out[i] always presents the stored output data bit of pin i.
- R9: In bank 0, writes cannot clear the direction bits of pins 7 and 8. Other banks have no such lock.
- R10: When the pin count is below 32, register bits at or above the pin count read 0 and ignore writes.
- R11: Any other offset reads 0, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | PIN_COUNT | Asynchronous pad input levels |
| pad_out | output | PIN_COUNT | Pad output values |
| pad_oe | output | PIN_COUNT | Pad drive enables |

## Verification
Two things can happen in the same cycle: a masked data write and a change of the pad inputs that the read port samples. The bench provokes this by changing pad_in on the same clock edge that a mask/data write lands. It then checks that pad_out takes only the unmasked bits at once, and that the read port shows the new pad levels exactly two edges later, with no interference from the write. A behavioural model is compared against the outputs on every clock, and a random phase mixes writes, addresses and pad changes.

// File: rtl/gmb_pkg.sv
`timescale 1ns/1ps
package gmb_pkg;

  localparam int unsigned HALF_W = 16;

  typedef enum logic [2:0] {
    SEL_LO   = 3'd0,
    SEL_HI   = 3'd1,
    SEL_DAT  = 3'd2,
    SEL_DIR  = 3'd3,
    SEL_OEN  = 3'd4,
    SEL_NONE = 3'd5
  } sel_e;

  // mask bit 1 keeps the current bit, mask bit 0 takes the new data bit
  function automatic logic [HALF_W-1:0] merge_half(input logic [HALF_W-1:0] cur,
                                                   input logic [31:0] word);
    return (cur & word[31:16]) | (word[15:0] & ~word[31:16]);
  endfunction

  function automatic logic [31:0] impl_mask(input int pins);
    if (pins >= 32) return 32'hFFFF_FFFF;
    return (32'd1 << pins) - 32'd1;
  endfunction

  // pins that may never be switched to input
  function automatic logic [31:0] lock_mask(input int bank);
    return (bank == 0) ? 32'h0000_0180 : 32'h0;
  endfunction

endpackage

// File: rtl/gmb_in_sync.sv
`timescale 1ns/1ps
module gmb_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gmb_cfg_reg.sv
`timescale 1ns/1ps
module gmb_cfg_reg #(
  parameter int           W    = 32,
  parameter logic [W-1:0] KEEP = '0,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] RST_VAL = KEEP & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (we) q <= (wdata | KEEP) & IMPL;
  end
endmodule

// File: rtl/gmb_out_data.sv
`timescale 1ns/1ps
module gmb_out_data
  import gmb_pkg::*;
#(
  parameter logic [31:0] IMPL = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  we_half,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [HALF_W-1:0] HM = IMPL[h*HALF_W +: HALF_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[h*HALF_W +: HALF_W] <= '0;
      else if (we_half[h])
        q[h*HALF_W +: HALF_W] <= merge_half(q[h*HALF_W +: HALF_W], wdata) & HM;
    end
  end
endmodule

// File: rtl/gpio_mask_bank.sv
`timescale 1ns/1ps
module gpio_mask_bank
  import gmb_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int BANK_ID   = 0,
  parameter int ADDR_W    = 5,
  parameter int OFF_LO    = 'h00,
  parameter int OFF_HI    = 'h04,
  parameter int OFF_DAT   = 'h08,
  parameter int OFF_DIR   = 'h0C,
  parameter int OFF_OEN   = 'h10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [PIN_COUNT-1:0] pad_in,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] pad_oe
);
  localparam logic [31:0] IMPL = impl_mask(PIN_COUNT);
  localparam logic [31:0] LOCK = lock_mask(BANK_ID) & IMPL;

  // named internal events
  sel_e                 sel;
  logic                 wr_lo, wr_hi, wr_dir, wr_oen;
  logic [31:0]          dir_q, oen_q, dout_q, pin_lvl;
  logic [PIN_COUNT-1:0] pin_sync;

  always_comb begin
    if      (bus_addr == ADDR_W'(OFF_LO))  sel = SEL_LO;
    else if (bus_addr == ADDR_W'(OFF_HI))  sel = SEL_HI;
    else if (bus_addr == ADDR_W'(OFF_DAT)) sel = SEL_DAT;
    else if (bus_addr == ADDR_W'(OFF_DIR)) sel = SEL_DIR;
    else if (bus_addr == ADDR_W'(OFF_OEN)) sel = SEL_OEN;
    else                                   sel = SEL_NONE;
  end

  assign wr_lo  = bus_wr_en && (sel == SEL_LO);
  assign wr_hi  = bus_wr_en && (sel == SEL_HI);
  assign wr_dir = bus_wr_en && (sel == SEL_DIR);
  assign wr_oen = bus_wr_en && (sel == SEL_OEN);

  gmb_cfg_reg #(.W(32), .KEEP(LOCK), .IMPL(IMPL)) u_dir (
    .clk(clk), .rst_n(rst_n), .we(wr_dir), .wdata(bus_wdata), .q(dir_q)
  );

  gmb_cfg_reg #(.W(32), .KEEP(32'h0), .IMPL(IMPL)) u_oen (
    .clk(clk), .rst_n(rst_n), .we(wr_oen), .wdata(bus_wdata), .q(oen_q)
  );

  gmb_out_data #(.IMPL(IMPL)) u_dout (
    .clk(clk), .rst_n(rst_n), .we_half({wr_hi, wr_lo}), .wdata(bus_wdata), .q(dout_q)
  );

  gmb_in_sync #(.W(PIN_COUNT)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  assign pin_lvl = 32'(pin_sync);

  always_comb begin
    unique case (sel)
      SEL_DAT: bus_rdata = pin_lvl;
      SEL_DIR: bus_rdata = dir_q;
      SEL_OEN: bus_rdata = oen_q;
      default: bus_rdata = 32'h0;
    endcase
  end

  assign pad_out = dout_q[PIN_COUNT-1:0];
  assign pad_oe  = dir_q[PIN_COUNT-1:0] & oen_q[PIN_COUNT-1:0];

endmodule

// File: rtl/gpio_mask_bank_chk.sv
`timescale 1ns/1ps
module gpio_mask_bank_chk
  import gmb_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int BANK_ID   = 0,
  parameter int ADDR_W    = 5,
  parameter int OFF_LO    = 'h00,
  parameter int OFF_HI    = 'h04
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr_en,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [31:0]          dir_q,
  input logic [31:0]          oen_q,
  input logic [31:0]          dout_q,
  input logic [PIN_COUNT-1:0] pad_oe
);
  localparam logic [31:0] IMPL = impl_mask(PIN_COUNT);
  localparam logic [31:0] LOCK = lock_mask(BANK_ID) & IMPL;

  a_r9_locked_stay_out: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q & LOCK) == LOCK);

  a_r10_unimpl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q | oen_q | dout_q) & ~IMPL) == 32'h0);

  a_r2_masked_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == ADDR_W'(OFF_LO)) |=>
      ((dout_q[15:0] ^ $past(dout_q[15:0])) & $past(bus_wdata[31:16])) == 16'h0);

  a_r3_masked_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == ADDR_W'(OFF_HI)) |=>
      ((dout_q[31:16] ^ $past(dout_q[31:16])) & $past(bus_wdata[31:16])) == 16'h0);

  a_r4_write_only_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFF_LO) || bus_addr == ADDR_W'(OFF_HI)) |-> bus_rdata == 32'h0);

  a_r7_drive_needs_output: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(pad_oe) & ~dir_q) == 32'h0);

  a_r6_idle_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_en |=> ($stable(dir_q) && $stable(oen_q) && $stable(dout_q)));

endmodule

bind gpio_mask_bank gpio_mask_bank_chk #(
  .PIN_COUNT(PIN_COUNT), .BANK_ID(BANK_ID), .ADDR_W(ADDR_W),
  .OFF_LO(OFF_LO), .OFF_HI(OFF_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dir_q(dir_q), .oen_q(oen_q),
  .dout_q(dout_q), .pad_oe(pad_oe)
);

// File: tb/gpio_mask_bank_tb.sv
`timescale 1ns/1ps
module gpio_mask_bank_tb;
  localparam logic [4:0] A_LO = 5'h00, A_HI = 5'h04, A_DAT = 5'h08,
                         A_DIR = 5'h0C, A_OEN = 5'h10, A_BAD = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = 5'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] pin_in = 32'h0;
  logic [31:0] rdata, n_rdata;
  logic [31:0] pad_out, pad_oe;
  logic [21:0] n_out, n_oe;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_mask_bank #(.PIN_COUNT(32), .BANK_ID(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .pad_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  gpio_mask_bank #(.PIN_COUNT(22), .BANK_ID(1)) u_dut_narrow (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(n_rdata), .pad_in(pin_in[21:0]),
    .pad_out(n_out), .pad_oe(n_oe)
  );

  // behavioural reference for the 32-pin bank 0 instance
  logic [31:0] m_dir, m_oe, m_out;
  logic [31:0] hist[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_write(input logic [4:0] a, input logic [31:0] d);
    case (a)
      A_LO: for (int i = 0; i < 16; i++) if (!d[16+i]) m_out[i] = d[i];
      A_HI: for (int i = 0; i < 16; i++) if (!d[16+i]) m_out[16+i] = d[i];
      A_DIR: m_dir = d | 32'h0000_0180;
      A_OEN: m_oe = d;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_read(input logic [4:0] a);
    case (a)
      A_DAT:   return (hist.size() >= 2) ? hist[1] : 32'h0;
      A_DIR:   return m_dir;
      A_OEN:   return m_oe;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(input logic [4:0] a);
    case (a)
      A_LO, A_HI: return "R4 write-only read";
      A_DAT:      return "R5 pad level read";
      A_DIR, A_OEN: return "R6 config read";
      default:    return "R11 unmapped read";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 32'h0000_0180; m_oe = 32'h0; m_out = 32'h0;
      hist.delete();
    end else begin
      hist.push_front(pin_in);
      if (hist.size() > 2) void'(hist.pop_back());
      if (wr_en) model_write(addr, wdata);
    end
    #2;
    if (rst_n && !done) begin
      chk(pad_out == m_out, "R8 pad_out vs model", pad_out, m_out);
      chk(pad_oe == (m_dir & m_oe), "R7 pad_oe vs model", pad_oe, m_dir & m_oe);
      chk(rdata == model_read(addr), read_tag(addr), rdata, model_read(addr));
    end
  end

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, checked while reset is still held
    chk(pad_out == 32'h0, "R1 reset pad_out", pad_out, 32'h0);
    chk(pad_oe == 32'h0, "R1 reset pad_oe", pad_oe, 32'h0);
    addr = A_DIR; #1;
    chk(rdata == 32'h0000_0180, "R1 reset direction", rdata, 32'h0000_0180);
    chk(n_rdata == 32'h0, "R1 reset direction other bank", n_rdata, 32'h0);
    rst_n = 1'b1;
    rd(A_OEN, 32'h0, "R1 reset output enable");

    // R9: locked pins survive a clear
    bus_wr(A_DIR, 32'h0);
    rd(A_DIR, 32'h0000_0180, "R9 locked direction bits");
    bus_wr(A_OEN, 32'h0000_0100);
    @(negedge clk); #1;
    chk(pad_oe == 32'h0000_0100, "R7 locked pin drives", pad_oe, 32'h0000_0100);

    bus_wr(A_DIR, 32'hFFFF_FFFF);
    bus_wr(A_OEN, 32'h0000_FFFF);
    rd(A_OEN, 32'h0000_FFFF, "R6 output enable readback");
    @(negedge clk); #1;
    chk(pad_oe == 32'h0000_FFFF, "R7 enable gating", pad_oe, 32'h0000_FFFF);

    // R10: narrow bank drops bits at and above pin 22
    addr = A_DIR; #1;
    chk(n_rdata == 32'h003F_FFFF, "R10 narrow direction bits", n_rdata, 32'h003F_FFFF);

    // R2: low port, full then partial mask
    bus_wr(A_LO, 32'h0000_A5A5);
    @(negedge clk); #1;
    chk(pad_out == 32'h0000_A5A5, "R2 low full write", pad_out, 32'h0000_A5A5);
    bus_wr(A_LO, 32'hFF00_0033);
    @(negedge clk); #1;
    chk(pad_out == 32'h0000_A533, "R2 low partial mask", pad_out, 32'h0000_A533);
    bus_wr(A_LO, 32'hFFFF_FFFF);
    @(negedge clk); #1;
    chk(pad_out == 32'h0000_A533, "R2 low all masked", pad_out, 32'h0000_A533);

    // R3: high port
    bus_wr(A_HI, 32'h0000_1234);
    @(negedge clk); #1;
    chk(pad_out == 32'h1234_A533, "R3 high full write", pad_out, 32'h1234_A533);
    bus_wr(A_HI, 32'hFFFE_0001);
    @(negedge clk); #1;
    chk(pad_out == 32'h1235_A533, "R3 high single pin", pad_out, 32'h1235_A533);
    chk(n_out == 22'h35_A533, "R10 narrow output bits", {10'h0, n_out}, 32'h0035_A533);

    // R4 and R11
    rd(A_LO, 32'h0, "R4 low port reads zero");
    rd(A_HI, 32'h0, "R4 high port reads zero");
    bus_wr(A_DAT, 32'hFFFF_FFFF);
    bus_wr(A_BAD, 32'hFFFF_FFFF);
    rd(A_BAD, 32'h0, "R11 unmapped reads zero");
    rd(A_OEN, 32'h0000_FFFF, "R11 stray writes change nothing");
    @(negedge clk); #1;
    chk(pad_out == 32'h1235_A533, "R5 data port write ignored", pad_out, 32'h1235_A533);

    // R5: pad change in the same cycle as a masked write
    @(negedge clk);
    pin_in = 32'hCAFE_0F0F; wr_en = 1'b1; addr = A_LO; wdata = 32'hFFF0_0005;
    @(negedge clk); wr_en = 1'b0; addr = A_DAT; #1;
    chk(pad_out == 32'h1235_A535, "R2 write beside pad change", pad_out, 32'h1235_A535);
    chk(rdata == 32'h0, "R5 one edge after change", rdata, 32'h0);
    @(negedge clk); #1;
    chk(rdata == 32'hCAFE_0F0F, "R5 two edges after change", rdata, 32'hCAFE_0F0F);
    chk(n_rdata == 32'h003E_0F0F, "R10 narrow pad read", n_rdata, 32'h003E_0F0F);

    // mixed random traffic against the model
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      wr_en  = 1'($urandom_range(0, 1));
      addr   = 5'(4 * $urandom_range(0, 5));
      wdata  = $urandom;
      pin_in = $urandom;
    end
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule